// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a clocked on-chip request bus and an external 32K x 8 asynchronous static RAM. It accepts one read or write at a time through a valid/ready handshake. It then drives the memory's active-low chip select, read strobe and write strobe, together with a 15-bit address and a split 8-bit data bus (out, in and drive enable). Every phase of the access lasts a whole number of clocks. Each count is worked out at elaboration from a clock-period parameter and a set of nanosecond minimums, so the same code can follow a different clock or a different memory grade by changing parameters only.

A read holds select and read strobe low for the access count. The controller samples the data bus on the last clock of that phase and reports it with a one-cycle response pulse. It then lifts both strobes and waits through a release gap, so the memory has let go of the bus before the controller could drive it. A write never lowers the read strobe. It spends one clock with select low and data driven, then pulses the write strobe for the pulse count, then keeps select low and data driven for at least one more clock. The rising write strobe ends the write. A cycle-length guard stretches the final phase of either operation until the minimum cycle time has passed since the request was accepted.

The state machine has six states. IDLE is ready; a request goes to RD_ACCESS or to WR_SETUP. RD_ACCESS goes to RD_RELEASE when its count ends. RD_RELEASE goes to IDLE once its count has ended and the cycle guard is satisfied. WR_SETUP goes to WR_PULSE after one clock. WR_PULSE goes to WR_RECOVER when its count ends. WR_RECOVER goes to IDLE on the same condition as RD_RELEASE.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, with no request, select, read strobe and write strobe are high (1 = inactive), the data driver is off, ready is high and the response pulse is low.
- R2: A request is taken only on a clock edge where ready is high and valid is high. Ready stays low from that edge until the operation has returned to idle. A valid held high while busy is accepted only after ready returns.
- R3: A read holds select low, read strobe low and write strobe high for exactly N_ACC clocks. N_ACC = ceil(max(address access time, strobe access time) / clock period).
- R4: The read data is sampled at the clock edge that ends the N_ACC-th access clock. The response pulse is high for exactly the following clock, carrying the byte stored at the read address.
- R5: After the access phase, select and read strobe are both high for max(N_REL, N_CYC - N_ACC) clocks, with the data driver off, before ready returns. N_REL = ceil(bus release time / clock period).
- R6: A write keeps the read strobe high throughout. It runs 1 clock with select low and write strobe high, then N_WP clocks with write strobe low, then max(1, N_CYC - 1 - N_WP) clocks with write strobe high and select low. The data driver is on and carries the request's byte in all of these clocks. N_WP = ceil(max(pulse width, data setup) / clock period). The write strobe is never low while select is high.
- R7: The memory address changes only while the write strobe is high, and it stays at the request's address for the whole operation.
- R8: Every phase count is ceil(ns / clock period) and at least 1. The busy time of any operation is at least N_CYC = ceil(cycle time / clock period) clocks.
- R9: The controller never enables its data driver while the read strobe is low, or within the release time after the read strobe or select last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock read data pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 8 | Byte to drive on the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the controller with a 20 ns clock and a 110 ns cycle minimum. The other timing values stay at their defaults, so N_ACC = 4, N_WP = 3, N_REL = 2 and N_CYC = 6. With these values the cycle guard, and not the phase count, sets the length of the write recovery phase. The read release phase ends at the point where both limits agree. The memory model in the bench returns correct data only after the nanosecond access times have elapsed, which shows whether the controller samples one clock too early. It also tracks the memory's bus release window to catch drive contention, and times the write pulse and the data setup in nanoseconds.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctrl_state_t;

    // Whole clocks covering a nanosecond minimum, never fewer than one.
    function automatic int clocks_for(input int ns, input int clk_ns);
        int n;
        n = (ns + clk_ns - 1) / clk_ns;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
module sram_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign last = (cnt_q == (len - W'(1)));

    // Saturates on the last clock so a phase can be held open.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/sram_cycle_guard.sv
`timescale 1ns/1ps
module sram_cycle_guard #(
    parameter int N_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(N_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q >= CW'(N_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (!done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/sram_datapath.sv
`timescale 1ns/1ps
module sram_datapath #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_wdata,
    output logic [DW-1:0] out_rdata,
    output logic          out_rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_wdata <= '0;
        end else if (load) begin
            out_addr  <= in_addr;
            out_wdata <= in_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_rdata  <= '0;
            out_rvalid <= 1'b0;
        end else begin
            out_rvalid <= capture;
            if (capture) begin
                out_rdata <= bus_in;
            end
        end
    end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW         = 15,
    parameter int DW         = 8,
    parameter int CLK_NS     = 20,
    parameter int T_CYC_NS   = 70,
    parameter int T_ACC_NS   = 70,
    parameter int T_OEACC_NS = 50,
    parameter int T_WP_NS    = 50,
    parameter int T_DSU_NS   = 40,
    parameter int T_REL_NS   = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_oe
);
    localparam int N_ACC = clocks_for(max_of(T_ACC_NS, T_OEACC_NS), CLK_NS);
    localparam int N_WP  = clocks_for(max_of(T_WP_NS, T_DSU_NS), CLK_NS);
    localparam int N_REL = clocks_for(T_REL_NS, CLK_NS);
    localparam int N_CYC = clocks_for(T_CYC_NS, CLK_NS);
    localparam int N_MAX = max_of(max_of(N_ACC, N_WP), N_REL);
    localparam int PW    = $clog2(N_MAX + 1);

    ctrl_state_t st_q, st_d;
    logic        accept;
    logic        phase_last;
    logic        phase_clear;
    logic [PW-1:0] phase_len;
    logic        cyc_done;
    logic        capture;

    assign accept      = (st_q == ST_IDLE) && req_valid;
    assign phase_clear = (st_d != st_q);
    assign capture     = (st_q == ST_RD_ACCESS) && phase_last;
    assign req_ready   = (st_q == ST_IDLE);

    always_comb begin
        unique case (st_q)
            ST_RD_ACCESS:  phase_len = PW'(N_ACC);
            ST_RD_RELEASE: phase_len = PW'(N_REL);
            ST_WR_PULSE:   phase_len = PW'(N_WP);
            default:       phase_len = PW'(1);
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS: begin
                if (phase_last) st_d = ST_RD_RELEASE;
            end
            ST_RD_RELEASE: begin
                if (phase_last && cyc_done) st_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                st_d = ST_WR_PULSE;
            end
            ST_WR_PULSE: begin
                if (phase_last) st_d = ST_WR_RECOVER;
            end
            ST_WR_RECOVER: begin
                if (phase_last && cyc_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Strobe outputs decoded from the state register only
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (st_q)
            ST_IDLE:       ;
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_RD_RELEASE: ;
            ST_WR_SETUP: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_RECOVER: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    sram_phase_cnt #(.W(PW)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_clear),
        .len   (phase_len),
        .last  (phase_last)
    );

    sram_cycle_guard #(.N_CYC(N_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .done  (cyc_done)
    );

    sram_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .capture    (capture),
        .bus_in     (mem_dq_in),
        .out_addr   (mem_addr),
        .out_wdata  (mem_dq_out),
        .out_rdata  (rsp_rdata),
        .out_rvalid (rsp_valid)
    );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R6

    AST_WE_WITHOUT_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R6

    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> (mem_dq_oe && $stable(mem_dq_out))); // R6

    AST_ADDR_HELD_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R7

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R9

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready); // R2
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;
    localparam int CLK = 20;
    localparam int CYC_NS = 110;
    // Expected counts from the requirements: ceil(ns/20)
    localparam int NA = 4;   // max(70,50)
    localparam int NW = 3;   // max(50,40)
    localparam int NR = 2;   // 30
    localparam int NC = 6;   // 110
    localparam int LEN_RD = NA + ((NR > NC - NA) ? NR : NC - NA);
    localparam int LEN_WR = 1 + NW + ((1 > NC - 1 - NW) ? 1 : NC - 1 - NW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK/2) clk = ~clk;

    sram_strobe_ctrl #(.CLK_NS(CLK), .T_CYC_NS(CYC_NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // ---------------- behavioural memory with ns timing ----------------
    byte unsigned sram[int];
    realtime t_addr = -1000.0, t_ce_fall = -1000.0, t_oe_fall = -1000.0;
    realtime t_release = -1000.0, t_we_fall = -1000.0, t_data = -1000.0;

    function automatic byte unsigned sram_rd(input int a);
        return sram.exists(a) ? sram[a] : 8'h00;
    endfunction

    always @(mem_addr) begin
        if (rst_n && !mem_we_n) chk("R7 addr moved with write strobe low", 1, 0);
        t_addr = $realtime;
    end
    always @(negedge mem_ce_n) t_ce_fall = $realtime;
    always @(negedge mem_oe_n) t_oe_fall = $realtime;
    always @(posedge mem_oe_n or posedge mem_ce_n) t_release = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(mem_dq_out) t_data = $realtime;
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) begin
            chk("R6 write pulse >= 50ns", ($realtime - t_we_fall >= 50.0) ? 1 : 0, 1);
            chk("R6 data setup >= 40ns", ($realtime - t_data >= 40.0) ? 1 : 0, 1);
            sram[int'(mem_addr)] = mem_dq_out;
        end
    end

    always @(negedge clk) begin
        automatic logic mem_drives;
        automatic realtime t_sel;
        mem_drives = (!mem_ce_n && !mem_oe_n && mem_we_n) ||
                     ($realtime - t_release < 30.0);
        if (rst_n && mem_dq_oe && mem_drives) chk("R9 bus contention", 1, 0);
        t_sel = (t_addr > t_ce_fall) ? t_addr : t_ce_fall;
        if (!mem_ce_n && !mem_oe_n && mem_we_n &&
            ($realtime - t_sel >= 70.0) && ($realtime - t_oe_fall >= 50.0))
            mem_dq_in = sram_rd(int'(mem_addr));
        else
            mem_dq_in = ~sram_rd(int'(mem_addr));
    end

    // ---------------- cycle-by-cycle reference model ----------------
    byte unsigned ref_mem[int];
    int m_mode = 0;  // 0 idle, 1 read, 2 write
    int m_t = 0;
    int m_addr = 0;
    int m_data = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_t = 0;
        end else if (m_mode == 0) begin
            if (req_valid) begin
                m_mode = req_write ? 2 : 1;
                m_t = 1;
                m_addr = int'(req_addr);
                m_data = int'(req_wdata);
                if (req_write) ref_mem[m_addr] = req_wdata;
            end
        end else if (m_t == ((m_mode == 1) ? LEN_RD : LEN_WR)) begin
            m_mode = 0; m_t = 0;
        end else begin
            m_t++;
        end
    end

    always @(negedge clk) begin
        if (m_mode == 0) begin
            chk("R1/R2 idle select", int'(mem_ce_n), 1);
            chk("R1 idle read strobe", int'(mem_oe_n), 1);
            chk("R1 idle write strobe", int'(mem_we_n), 1);
            chk("R1 idle driver", int'(mem_dq_oe), 0);
            chk("R2 ready in idle", int'(req_ready), 1);
            chk("R1 no response in idle", int'(rsp_valid), 0);
        end else begin
            chk("R2 ready low while busy", int'(req_ready), 0);
            chk("R7 address held", int'(mem_addr), m_addr);
            if (m_mode == 1) begin
                chk("R3/R5 read strobe", int'(mem_oe_n), (m_t <= NA) ? 0 : 1);
                chk("R3/R5 select", int'(mem_ce_n), (m_t <= NA) ? 0 : 1);
                chk("R3 write strobe high", int'(mem_we_n), 1);
                chk("R5 driver off", int'(mem_dq_oe), 0);
                chk("R4 response pulse", int'(rsp_valid), (m_t == NA + 1) ? 1 : 0);
                if (m_t == NA + 1) begin
                    chk("R4 read byte", int'(rsp_rdata),
                        ref_mem.exists(m_addr) ? int'(ref_mem[m_addr]) : 0);
                end
            end else begin
                chk("R6 read strobe high", int'(mem_oe_n), 1);
                chk("R6 select low", int'(mem_ce_n), 0);
                chk("R6 write strobe", int'(mem_we_n),
                    (m_t >= 2 && m_t <= 1 + NW) ? 0 : 1);
                chk("R6 driver on", int'(mem_dq_oe), 1);
                chk("R6 write byte", int'(mem_dq_out), m_data);
                chk("R8 no response during write", int'(rsp_valid), 0);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic wr, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a[14:0];
        req_wdata = d[7:0];
        forever begin
            if (req_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic drain();
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R8: boundary addresses, back-to-back requests held while busy
        issue(1'b1, 0, 8'h3C);
        issue(1'b1, 15'h7FFF, 8'hC3);
        issue(1'b0, 0, 0);
        issue(1'b0, 15'h7FFF, 0);
        issue(1'b0, 15'h1234, 0);         // never written
        drain();
        // write then read same location, then overwrite
        issue(1'b1, 15'h1234, 8'hA5);
        issue(1'b0, 15'h1234, 0);
        issue(1'b1, 15'h1234, 8'h5A);
        issue(1'b0, 15'h1234, 0);
        drain();
        // isolated single operations with idle gaps
        issue(1'b0, 15'h7FFF, 0);
        drain();
        issue(1'b1, 15'h0001, 8'hFF);
        drain();
        // mixed pseudo-random traffic
        for (int i = 0; i < 40; i++) begin
            automatic int a = (i * 2731 + 17) % 64;
            automatic int d = (i * 97 + 5) % 256;
            issue((i % 3) != 1, a * 512 + (i % 7), d);
        end
        for (int i = 0; i < 20; i++) begin
            issue(1'b0, ((i * 2731 + 17) % 64) * 512 + (i % 7), 0);
        end
        drain();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (150000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule